// File: doc/BRIEF.md
# ASID-Tagged I/O Translation Cache

This block caches completed address translations for an I/O memory-management unit. Each entry is tagged with a 16-bit address-space identifier and an input address region. Each entry stores the output page, an address mask that sets the size of the mapped region, and two permission bits. A client presents an identifier and an address on the lookup port and gets hit or miss, the translated address and the permissions exactly one cycle later. The page-table walker installs new translations through the fill port.

Software-driven maintenance arrives on the invalidation port. One command can drop the whole cache, every entry of one identifier, or the single entry covering one identifier and address. A command completes in the cycle it is presented. A done pulse follows one cycle later. Lookups are held off (ready low) while the command is on the port. A small control state machine has two states. ST_SERVE is the normal state. ST_ACK is the cycle that drives the done pulse. The transition ST_SERVE to ST_ACK is taken when a command is accepted. The transition ST_ACK to ST_SERVE is taken when no new command follows. ST_ACK stays in ST_ACK when commands come back to back.

Top module: `iotlb_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup misses. Also after reset `inv_done` is low and `lkp_ready` is high.
- R2: A lookup accepted at a clock edge (`lkp_valid` and `lkp_ready` both high) raises `rsp_valid` for exactly the following cycle. On a hit, `rsp_addr` and `rsp_perm` are valid in that same cycle. `rsp_perm` bit 0 is read and bit 1 is write. `rsp_hit` is never high without `rsp_valid`.
- R3: A hit requires the stored identifier to equal `lkp_asid` and the stored address to equal `lkp_addr`. A matching address under a different identifier misses, and so does a matching identifier with a different address.
- R4: Address bits under a set bit of the entry mask are ignored in the compare. The translated address takes the output page above the mask and the lookup address bits under the mask.
- R5: An invalidate with `inv_mode` 2'b00 (or 2'b11) clears every entry.
- R6: An invalidate with `inv_mode` 2'b01 clears every entry whose identifier equals `inv_asid`, whatever its address. Entries of other identifiers stay.
- R7: An invalidate with `inv_mode` 2'b10 clears only the entry that matches both `inv_asid` and `inv_addr`. The address is compared above that entry's mask.
- R8: `inv_done` is high for exactly the cycle after each cycle with `inv_valid` high. `lkp_ready` is low in every cycle with `inv_valid` high.
- R9: When a fill and an invalidation share a cycle, the invalidation wins. If the filled key is covered by the command, the entry does not become valid. A fill that is not covered by the command becomes valid normally.
- R10: A fill goes to the lowest-numbered free entry. When all entries are valid, a round-robin pointer picks the victim. The pointer starts at entry 0 after reset and advances by one for each replacement.
- R11: A fill whose identifier and address hit an existing entry overwrites that entry in place, so a key never occupies two entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_ready | output | 1 | Lookup can be accepted this cycle |
| lkp_asid | input | ASID_W | Lookup identifier |
| lkp_addr | input | ADDR_W | Lookup input address |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_addr | output | ADDR_W | Translated address |
| rsp_perm | output | PERM_W | Permissions, bit 0 read, bit 1 write |
| fill_valid | input | 1 | Install a translation |
| fill_asid | input | ASID_W | Identifier of the new entry |
| fill_addr | input | ADDR_W | Input address of the new entry |
| fill_out | input | ADDR_W | Output page of the new entry |
| fill_mask | input | ADDR_W | Offset mask of the new entry |
| fill_perm | input | PERM_W | Permissions of the new entry |
| inv_valid | input | 1 | Invalidation command |
| inv_mode | input | 2 | 00/11 all, 01 by identifier, 10 by identifier and address |
| inv_asid | input | ASID_W | Identifier for selective modes |
| inv_addr | input | ADDR_W | Address for mode 10 |
| inv_done | output | 1 | Command completed pulse |

## Verification
The assertions check the cycle-level rules on every cycle. These are the one-cycle lookup latency, the done pulse that follows each command, ready dropping during a command, the empty valid vector after a global flush, and that no lookup ever hits two entries. Only the bench scenarios can show the data rules. These cover which entries survive each kind of invalidation, masked compare on large mappings, same-cycle fill and invalidate priority, in-place refill, and the round-robin victim order once the cache is full. The bench checks them against an associative reference model of the stored keys.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;
    typedef enum logic [1:0] {
        INV_ALL      = 2'b00,
        INV_BY_ASID  = 2'b01,
        INV_BY_ADDR  = 2'b10,
        INV_ALL_ALT  = 2'b11
    } inv_mode_e;

    typedef enum logic {
        ST_SERVE = 1'b0,
        ST_ACK   = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/iotlb_match.sv
module iotlb_match #(
    parameter int ENTRIES = 16,
    parameter int ASID_W  = 16,
    parameter int ADDR_W  = 32
) (
    input  logic [ENTRIES-1:0]             valid_i,
    input  logic [ENTRIES-1:0][ASID_W-1:0] asid_i,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] base_i,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] mask_i,
    input  logic [ASID_W-1:0]              key_asid,
    input  logic [ADDR_W-1:0]              key_addr,
    input  logic                           use_addr,
    output logic [ENTRIES-1:0]             match_o
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic asid_eq;
        logic addr_eq;
        assign asid_eq    = (asid_i[g] == key_asid);
        assign addr_eq    = (((base_i[g] ^ key_addr) & ~mask_i[g]) == '0);
        assign match_o[g] = valid_i[g] && asid_eq && (!use_addr || addr_eq);
    end
endmodule

// File: rtl/iotlb_victim.sv
module iotlb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic               advance,
    output logic               free_any,
    output logic [IDX_W-1:0]   free_idx,
    output logic [IDX_W-1:0]   rr_idx
);
    logic [IDX_W-1:0] rr_q;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (advance) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    assign rr_idx = rr_q;
endmodule

// File: rtl/iotlb_ctrl.sv
module iotlb_ctrl
    import iotlb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inv_valid,
    input  logic lkp_valid,
    output logic lkp_ready,
    output logic lkp_fire,
    output logic inv_done
);
    ctl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SERVE: if (inv_valid)  state_d = ST_ACK;
            ST_ACK:   if (!inv_valid) state_d = ST_SERVE;
            default:  state_d = ST_SERVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SERVE;
        else        state_q <= state_d;
    end

    always_comb begin
        inv_done  = (state_q == ST_ACK);
        lkp_ready = !inv_valid;
        lkp_fire  = lkp_valid && !inv_valid;
    end
endmodule

// File: rtl/iotlb_cache.sv
module iotlb_cache
    import iotlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ASID_W  = 16,
    parameter int ADDR_W  = 32,
    parameter int PERM_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lkp_valid,
    output logic              lkp_ready,
    input  logic [ASID_W-1:0] lkp_asid,
    input  logic [ADDR_W-1:0] lkp_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [PERM_W-1:0] rsp_perm,
    input  logic              fill_valid,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [ADDR_W-1:0] fill_out,
    input  logic [ADDR_W-1:0] fill_mask,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              inv_valid,
    input  logic [1:0]        inv_mode,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic [ADDR_W-1:0] inv_addr,
    output logic              inv_done
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] base_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] mask_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] out_q;
    logic [ENTRIES-1:0][PERM_W-1:0] perm_q;

    logic [ENTRIES-1:0] lk_hit;
    logic [ENTRIES-1:0] fl_dup;
    logic [ENTRIES-1:0] iv_sel;
    logic [ENTRIES-1:0] kill;
    logic               lkp_fire;
    logic               free_any;
    logic [IDX_W-1:0]   free_idx;
    logic [IDX_W-1:0]   rr_idx;
    logic               dup_any;
    logic [IDX_W-1:0]   dup_idx;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   tgt_idx;
    logic               advance;
    logic               fill_killed;
    logic               inv_global;
    inv_mode_e          mode;

    assign mode       = inv_mode_e'(inv_mode);
    assign inv_global = (mode == INV_ALL) || (mode == INV_ALL_ALT);

    iotlb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .inv_valid (inv_valid),
        .lkp_valid (lkp_valid),
        .lkp_ready (lkp_ready),
        .lkp_fire  (lkp_fire),
        .inv_done  (inv_done)
    );

    iotlb_match #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .ADDR_W(ADDR_W)) u_lkp_match (
        .valid_i (valid_q), .asid_i (asid_q), .base_i (base_q), .mask_i (mask_q),
        .key_asid (lkp_asid), .key_addr (lkp_addr), .use_addr (1'b1),
        .match_o (lk_hit)
    );

    iotlb_match #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .ADDR_W(ADDR_W)) u_fill_match (
        .valid_i (valid_q), .asid_i (asid_q), .base_i (base_q), .mask_i (mask_q),
        .key_asid (fill_asid), .key_addr (fill_addr), .use_addr (1'b1),
        .match_o (fl_dup)
    );

    iotlb_match #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .ADDR_W(ADDR_W)) u_inv_match (
        .valid_i (valid_q), .asid_i (asid_q), .base_i (base_q), .mask_i (mask_q),
        .key_asid (inv_asid), .key_addr (inv_addr), .use_addr (mode == INV_BY_ADDR),
        .match_o (iv_sel)
    );

    iotlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (valid_q),
        .advance  (advance),
        .free_any (free_any),
        .free_idx (free_idx),
        .rr_idx   (rr_idx)
    );

    always_comb begin
        dup_any = 1'b0;
        dup_idx = '0;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (fl_dup[i]) begin
                dup_any = 1'b1;
                dup_idx = IDX_W'(i);
            end
            if (lk_hit[i]) hit_idx = IDX_W'(i);
        end
    end

    always_comb begin
        kill = '0;
        if (inv_valid) kill = inv_global ? '1 : iv_sel;
    end

    always_comb begin
        fill_killed = 1'b0;
        if (inv_valid) begin
            if (inv_global) begin
                fill_killed = 1'b1;
            end else if (fill_asid == inv_asid) begin
                fill_killed = (mode == INV_BY_ASID) ||
                              (((fill_addr ^ inv_addr) & ~fill_mask) == '0);
            end
        end
    end

    assign tgt_idx = dup_any ? dup_idx : (free_any ? free_idx : rr_idx);
    assign advance = fill_valid && !dup_any && !free_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_q & ~kill;
            if (fill_valid) valid_q[tgt_idx] <= !fill_killed;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_valid) begin
            asid_q[tgt_idx] <= fill_asid;
            base_q[tgt_idx] <= fill_addr & ~fill_mask;
            mask_q[tgt_idx] <= fill_mask;
            out_q[tgt_idx]  <= fill_out & ~fill_mask;
            perm_q[tgt_idx] <= fill_perm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_addr  <= '0;
            rsp_perm  <= '0;
        end else begin
            rsp_valid <= lkp_fire;
            rsp_hit   <= lkp_fire && (lk_hit != '0);
            rsp_addr  <= out_q[hit_idx] | (lkp_addr & mask_q[hit_idx]);
            rsp_perm  <= (lk_hit != '0) ? perm_q[hit_idx] : '0;
        end
    end
endmodule

// File: rtl/iotlb_cache_chk.sv
module iotlb_cache_chk #(
    parameter int ENTRIES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               inv_valid,
    input logic [1:0]         inv_mode,
    input logic               inv_done,
    input logic               lkp_valid,
    input logic               lkp_ready,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [ENTRIES-1:0] valid_q,
    input logic [ENTRIES-1:0] lk_hit
);
    // R8
    done_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |=> inv_done);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inv_valid |=> !inv_done);
    // R8
    lookup_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> !lkp_ready);
    // R2
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid && lkp_ready) |=> rsp_valid);
    // R2
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lkp_valid && lkp_ready) |=> !rsp_valid);
    // R2
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);
    // R5
    global_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && (inv_mode[1] == inv_mode[0])) |=> (valid_q == '0));
    // R11
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit));
endmodule

bind iotlb_cache iotlb_cache_chk #(.ENTRIES(ENTRIES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .inv_valid (inv_valid),
    .inv_mode  (inv_mode),
    .inv_done  (inv_done),
    .lkp_valid (lkp_valid),
    .lkp_ready (lkp_ready),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .valid_q   (valid_q),
    .lk_hit    (lk_hit)
);

// File: tb/iotlb_cache_tb.sv
module iotlb_cache_tb_top;
    localparam int ASID_W = 16;
    localparam int ADDR_W = 32;
    localparam int PERM_W = 2;
    localparam logic [ADDR_W-1:0] PG = 32'h0000_0FFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lkp_valid = 1'b0, lkp_ready;
    logic [ASID_W-1:0] lkp_asid = '0;
    logic [ADDR_W-1:0] lkp_addr = '0;
    logic rsp_valid, rsp_hit;
    logic [ADDR_W-1:0] rsp_addr;
    logic [PERM_W-1:0] rsp_perm;
    logic fill_valid = 1'b0;
    logic [ASID_W-1:0] fill_asid = '0;
    logic [ADDR_W-1:0] fill_addr = '0, fill_out = '0, fill_mask = '0;
    logic [PERM_W-1:0] fill_perm = '0;
    logic inv_valid = 1'b0;
    logic [1:0] inv_mode = '0;
    logic [ASID_W-1:0] inv_asid = '0;
    logic [ADDR_W-1:0] inv_addr = '0, inv_done_dummy;
    logic inv_done;

    int checks = 0;
    int failures = 0;

    typedef struct { logic [ADDR_W-1:0] out; logic [ADDR_W-1:0] mask; logic [PERM_W-1:0] perm; } ent_t;
    ent_t model [logic [ASID_W+ADDR_W-1:0]];

    always #10 clk = ~clk;

    iotlb_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .lkp_valid(lkp_valid), .lkp_ready(lkp_ready), .lkp_asid(lkp_asid), .lkp_addr(lkp_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr), .rsp_perm(rsp_perm),
        .fill_valid(fill_valid), .fill_asid(fill_asid), .fill_addr(fill_addr), .fill_out(fill_out),
        .fill_mask(fill_mask), .fill_perm(fill_perm),
        .inv_valid(inv_valid), .inv_mode(inv_mode), .inv_asid(inv_asid), .inv_addr(inv_addr),
        .inv_done(inv_done)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [ASID_W+ADDR_W-1:0] mkey(input logic [ASID_W-1:0] a, input logic [ADDR_W-1:0] b);
        return {a, b};
    endfunction

    task automatic model_fill(input logic [ASID_W-1:0] a, input logic [ADDR_W-1:0] ad,
                              input logic [ADDR_W-1:0] o, input logic [ADDR_W-1:0] m, input logic [PERM_W-1:0] p);
        logic [ASID_W+ADDR_W-1:0] kill_k;
        bit found = 0;
        foreach (model[k]) begin
            if (k[ASID_W+ADDR_W-1:ADDR_W] == a && ((k[ADDR_W-1:0] ^ ad) & ~model[k].mask) == '0) begin
                kill_k = k; found = 1;
            end
        end
        if (found) model.delete(kill_k);
        model[mkey(a, ad & ~m)] = '{out: o & ~m, mask: m, perm: p};
    endtask

    task automatic model_inv(input logic [1:0] md, input logic [ASID_W-1:0] a, input logic [ADDR_W-1:0] ad);
        logic [ASID_W+ADDR_W-1:0] dl [$];
        foreach (model[k]) begin
            if (md == 2'b00 || md == 2'b11) dl.push_back(k);
            else if (k[ASID_W+ADDR_W-1:ADDR_W] == a &&
                     (md == 2'b01 || ((k[ADDR_W-1:0] ^ ad) & ~model[k].mask) == '0)) dl.push_back(k);
        end
        foreach (dl[i]) model.delete(dl[i]);
    endtask

    task automatic do_fill(input logic [ASID_W-1:0] a, input logic [ADDR_W-1:0] ad,
                           input logic [ADDR_W-1:0] o, input logic [ADDR_W-1:0] m, input logic [PERM_W-1:0] p);
        @(negedge clk);
        fill_valid = 1; fill_asid = a; fill_addr = ad; fill_out = o; fill_mask = m; fill_perm = p;
        @(posedge clk); #1;
        fill_valid = 0;
        model_fill(a, ad, o, m, p);
    endtask

    task automatic do_inv(input logic [1:0] md, input logic [ASID_W-1:0] a, input logic [ADDR_W-1:0] ad,
                          input string req);
        @(negedge clk);
        inv_valid = 1; inv_mode = md; inv_asid = a; inv_addr = ad;
        #1 chk(lkp_ready == 1'b0, {req, "/R8 ready low"}, lkp_ready, 0);
        @(posedge clk); #1;
        inv_valid = 0;
        chk(inv_done == 1'b1, {req, "/R8 done pulse"}, inv_done, 1);
        model_inv(md, a, ad);
        @(posedge clk); #1;
        chk(inv_done == 1'b0, {req, "/R8 done single"}, inv_done, 0);
    endtask

    task automatic look(input logic [ASID_W-1:0] a, input logic [ADDR_W-1:0] ad, input string req);
        bit eh = 0;
        logic [ADDR_W-1:0] ea = '0;
        logic [PERM_W-1:0] ep = '0;
        foreach (model[k]) begin
            if (k[ASID_W+ADDR_W-1:ADDR_W] == a && ((k[ADDR_W-1:0] ^ ad) & ~model[k].mask) == '0) begin
                eh = 1; ea = model[k].out | (ad & model[k].mask); ep = model[k].perm;
            end
        end
        @(negedge clk);
        lkp_valid = 1; lkp_asid = a; lkp_addr = ad;
        @(posedge clk); #1;
        lkp_valid = 0;
        chk(rsp_valid == 1'b1, {req, " rsp_valid"}, rsp_valid, 1);
        chk(rsp_hit == eh, {req, " hit"}, rsp_hit, eh);
        if (eh) begin
            chk(rsp_addr == ea, {req, " addr"}, rsp_addr, ea);
            chk(rsp_perm == ep, {req, " perm"}, rsp_perm, ep);
        end
    endtask

    task automatic t_reset;
        chk(lkp_ready == 1'b1, "R1 ready after reset", lkp_ready, 1);
        chk(inv_done == 1'b0, "R1 done after reset", inv_done, 0);
        chk(rsp_valid == 1'b0, "R1 rsp idle", rsp_valid, 0);
        look(16'h0001, 32'h0000_5000, "R1 miss after reset");
    endtask

    task automatic t_basic;
        do_fill(16'h0001, 32'h0000_5000, 32'h8000_3000, PG, 2'b01);
        look(16'h0001, 32'h0000_5123, "R2 hit");
        look(16'h0002, 32'h0000_5123, "R3 other asid");
        look(16'h0001, 32'h0000_6000, "R3 other addr");
    endtask

    task automatic t_block;
        do_fill(16'h0003, 32'h0020_0000, 32'h4060_0000, 32'h001F_FFFF, 2'b11);
        look(16'h0003, 32'h0033_4567, "R4 block offset");
        look(16'h0003, 32'h0040_0000, "R4 outside block");
    endtask

    task automatic t_refill;
        do_fill(16'h0001, 32'h0000_5000, 32'h9000_0000, PG, 2'b10);
        look(16'h0001, 32'h0000_5123, "R11 refill");
        do_inv(2'b10, 16'h0001, 32'h0000_5000, "R7");
        look(16'h0001, 32'h0000_5123, "R11 no stale copy");
    endtask

    task automatic t_inv_asid;
        do_fill(16'h0004, 32'h0000_1000, 32'h1111_1000, PG, 2'b01);
        do_fill(16'h0004, 32'h0000_2000, 32'h1111_2000, PG, 2'b01);
        do_fill(16'h0005, 32'h0000_1000, 32'h2222_1000, PG, 2'b11);
        do_inv(2'b01, 16'h0004, 32'h0, "R6");
        look(16'h0004, 32'h0000_1010, "R6 asid gone a");
        look(16'h0004, 32'h0000_2010, "R6 asid gone b");
        look(16'h0005, 32'h0000_1010, "R6 other asid kept");
        look(16'h0003, 32'h0020_0004, "R6 block kept");
    endtask

    task automatic t_inv_addr;
        do_fill(16'h0006, 32'h0000_1000, 32'h3333_1000, PG, 2'b01);
        do_fill(16'h0006, 32'h0000_2000, 32'h3333_2000, PG, 2'b01);
        do_fill(16'h0007, 32'h0000_1000, 32'h4444_1000, PG, 2'b01);
        do_inv(2'b10, 16'h0006, 32'h0000_1abc, "R7");
        look(16'h0006, 32'h0000_1000, "R7 target gone");
        look(16'h0006, 32'h0000_2000, "R7 same asid kept");
        look(16'h0007, 32'h0000_1000, "R7 same addr kept");
    endtask

    task automatic t_inv_all;
        do_inv(2'b00, 16'h0000, 32'h0, "R5");
        look(16'h0005, 32'h0000_1010, "R5 all gone a");
        look(16'h0007, 32'h0000_1000, "R5 all gone b");
        do_fill(16'h0005, 32'h0000_1000, 32'h2222_1000, PG, 2'b11);
        do_inv(2'b11, 16'h0000, 32'h0, "R5 alt");
        look(16'h0005, 32'h0000_1010, "R5 alt gone");
    endtask

    task automatic t_fill_inv;
        @(negedge clk);
        fill_valid = 1; fill_asid = 16'h0008; fill_addr = 32'h0000_3000; fill_out = 32'h5555_3000;
        fill_mask = PG; fill_perm = 2'b01;
        inv_valid = 1; inv_mode = 2'b01; inv_asid = 16'h0008;
        @(posedge clk); #1;
        fill_valid = 0; inv_valid = 0;
        look(16'h0008, 32'h0000_3000, "R9 killed fill");
        @(negedge clk);
        fill_valid = 1; fill_asid = 16'h0009; fill_addr = 32'h0000_3000; fill_out = 32'h6666_3000;
        fill_mask = PG; fill_perm = 2'b10;
        inv_valid = 1; inv_mode = 2'b10; inv_asid = 16'h0009; inv_addr = 32'h0000_4000;
        @(posedge clk); #1;
        fill_valid = 0; inv_valid = 0;
        model_fill(16'h0009, 32'h0000_3000, 32'h6666_3000, PG, 2'b10);
        look(16'h0009, 32'h0000_3004, "R9 unrelated fill kept");
    endtask

    task automatic t_evict;
        do_inv(2'b00, 16'h0000, 32'h0, "R10 prep");
        for (int i = 0; i < 16; i++)
            do_fill(16'h000A, 32'(i) << 12, 32'hA000_0000 | (32'(i) << 12), PG, 2'b01);
        look(16'h000A, 32'h0000_F000, "R10 sixteen fit");
        do_fill(16'h000B, 32'h0000_0000, 32'hB000_0000, PG, 2'b11);
        model.delete(mkey(16'h000A, 32'h0000_0000));
        look(16'h000A, 32'h0000_0000, "R10 entry0 evicted");
        look(16'h000A, 32'h0000_1000, "R10 entry1 kept");
        look(16'h000B, 32'h0000_0000, "R10 new entry");
        do_fill(16'h000B, 32'h0000_1000, 32'hB000_1000, PG, 2'b11);
        model.delete(mkey(16'h000A, 32'h0000_1000));
        look(16'h000A, 32'h0000_1000, "R10 entry1 evicted");
        look(16'h000A, 32'h0000_2000, "R10 entry2 kept");
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        inv_done_dummy = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_block();
        t_refill();
        t_inv_asid();
        t_inv_addr();
        t_inv_all();
        t_fill_inv();
        t_evict();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule